// File: doc/BRIEF.md
# Battery Power Supervisor

This block sequences power for a battery-fed handset baseband. It sits in one of three states: off, a timed reset, and on. In the off state the supply regulators are disabled and the system reset line is held low. A power-key level or a charger-present level moves it into reset. Reset enables the regulators and keeps the reset line low for a fixed time, nominally 100 ms. At the end of that time the block releases reset only if the battery comparator reports a voltage above the start threshold.

Once the block is on, two events end normal operation. A battery that falls under the lower dropout threshold sends the block back to the timed reset. A watchdog that is not restarted by a falling edge on its kick input sends it all the way to off. The one exception is a connected charger with a healthy battery, which keeps the block on through a watchdog expiry.

The key, charger and kick inputs are asynchronous and each passes through a two-flop synchroniser. The two battery comparator flags are assumed to be synchronous to the slow clock. All timing comes from a free-running slow clock whose frequency is a parameter.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rstN` is low, `regEnable` and `resetN` are both 0. After `rstN` is released, both stay 0 for as long as `pwrKeyIn` and `chargerIn` are both 0.
- R2: From off, a high level on `pwrKeyIn` or `chargerIn` enters the reset state. The input is set up before clock edge 0. The reset state is reached on edge 3, which is two synchroniser flops plus the state register. In the reset state `regEnable` is 1 and `resetN` is 0.
- R3: The reset state lasts at least RST_CYCLES = CLK_HZ*RST_MS/1000 clock cycles. If `battAboveStart` is 1, the block leaves reset for on exactly RST_CYCLES edges after it entered reset.
- R4: The block never moves from reset to on while `battAboveStart` is 0. Once the reset time has elapsed, the block moves to on at the first edge where `battAboveStart` is sampled as 1.
- R5: In the on state `regEnable` is 1 and `resetN` is 1. `resetN` is never 1 while `regEnable` is 0.
- R6: In the on state, `battAboveDrop` sampled as 0 moves the block to reset at that edge. `resetN` falls and `regEnable` stays 1.
- R7: The watchdog is cleared whenever the block is not on. It is also cleared by a falling edge of the synchronised `wdogKick`. If it runs WD_CYCLES = CLK_HZ*WDOG_MS/1000 cycles in the on state without a clear, the block moves to off at that edge. The default timeout is 2000 ms.
- R8: A watchdog expiry while `chargerIn` (synchronised) is 1 and `battAboveStart` is 1 does not leave the on state. Instead the watchdog restarts.
- R9: A rising edge of `wdogKick`, or `wdogKick` held high, does not restart the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running slow clock |
| rstN | input | 1 | Asynchronous active-low power-on reset of the block itself |
| pwrKeyIn | input | 1 | Power key level, 1 = pressed, asynchronous |
| chargerIn | input | 1 | Charger present level, 1 = connected, asynchronous |
| battAboveStart | input | 1 | Battery comparator: 1 = above the start threshold |
| battAboveDrop | input | 1 | Battery comparator: 1 = above the dropout threshold |
| wdogKick | input | 1 | Watchdog kick; a falling edge restarts the timeout |
| regEnable | output | 1 | Regulator enable, 1 in reset and on |
| resetN | output | 1 | System reset, active low, 1 only in on |

## Verification
The bench measures the reset length and the watchdog timeout to the exact cycle. A design off by one in either counter, or with a missing synchroniser stage, moves an output one cycle away from where the bench samples it. One scenario holds the start comparator low past the reset time: a design that ignored it would release reset early, and one that failed to recover would stay in reset after the comparator rises. Other scenarios hold the kick input high, and keep a charger attached through several watchdog periods. These catch a design that restarts on the wrong edge, and one that powers off while the charger should keep it alive. A dropout scenario confirms the block returns to reset rather than to off.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RESET = 2'd1,
    ST_ON    = 2'd2
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rstTmrRun;   // reset timer counts while set, cleared otherwise
    logic wdRun;       // watchdog counts while set, cleared otherwise
    logic wdRestart;   // clear watchdog this cycle (charger hold-on)
  } dpStrobe_t;

endpackage

// File: rtl/pwr_sup_sync.sv
module pwr_sup_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pwr_sup_dpath.sv
module pwr_sup_dpath
  import pwr_sup_pkg::*;
#(
  parameter int RST_CYCLES  = 100,
  parameter int WD_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyRaw,
  input  logic       chgRaw,
  input  logic       kickRaw,
  input  dpStrobe_t  strobe,
  output logic       keyLvl,
  output logic       chgLvl,
  output logic       rstDone,
  output logic       wdExpired
);

  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam int WD_W  = $clog2(WD_CYCLES + 1);
  localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_CYCLES - 1);
  localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(WD_CYCLES - 1);

  logic [2:0] syncVec;
  logic       kickLvl;
  logic       kickPrev;
  logic       kickFall;
  logic [RST_W-1:0] rstCnt;
  logic [WD_W-1:0]  wdCnt;

  pwr_sup_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({kickRaw, chgRaw, keyRaw}),
    .syncOut (syncVec)
  );

  assign keyLvl  = syncVec[0];
  assign chgLvl  = syncVec[1];
  assign kickLvl = syncVec[2];

  // falling-edge detect on the synchronised kick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= kickLvl;
  end
  assign kickFall = kickPrev & ~kickLvl;

  // reset timer: counts up in reset, saturates at the last count
  assign rstDone = (rstCnt == RST_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rstCnt <= '0;
    else if (!strobe.rstTmrRun) rstCnt <= '0;
    else if (!rstDone)          rstCnt <= rstCnt + RST_W'(1);
  end

  // watchdog counter
  assign wdExpired = strobe.wdRun && (wdCnt == WD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        wdCnt <= '0;
    else if (!strobe.wdRun || kickFall || strobe.wdRestart) wdCnt <= '0;
    else if (wdCnt != WD_LAST)                        wdCnt <= wdCnt + WD_W'(1);
  end

endmodule

// File: rtl/pwr_sup_ctrl.sv
module pwr_sup_ctrl
  import pwr_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyLvl,
  input  logic       chgLvl,
  input  logic       rstDone,
  input  logic       wdExpired,
  input  logic       battAboveStart,
  input  logic       battAboveDrop,
  output dpStrobe_t  strobe,
  output logic       regEnable,
  output logic       resetN
);

  pwrState_t state, stateNext;
  logic      chargerHold;

  assign chargerHold = chgLvl && battAboveStart;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF: begin
        if (keyLvl || chgLvl) stateNext = ST_RESET;
      end
      ST_RESET: begin
        if (rstDone && battAboveStart) stateNext = ST_ON;
      end
      ST_ON: begin
        if (!battAboveDrop)                 stateNext = ST_RESET;
        else if (wdExpired && !chargerHold) stateNext = ST_OFF;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.rstTmrRun = (state == ST_RESET);
    strobe.wdRun     = (state == ST_ON);
    strobe.wdRestart = wdExpired && chargerHold;
  end

  assign regEnable = (state != ST_OFF);
  assign resetN    = (state == ST_ON);

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int CLK_HZ  = 32768,
  parameter int RST_MS  = 100,
  parameter int WDOG_MS = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrKeyIn,
  input  logic chargerIn,
  input  logic battAboveStart,
  input  logic battAboveDrop,
  input  logic wdogKick,
  output logic regEnable,
  output logic resetN
);

  localparam int RST_CYCLES = CLK_HZ * RST_MS / 1000;
  localparam int WD_CYCLES  = CLK_HZ * WDOG_MS / 1000;

  dpStrobe_t strobe;
  logic keyLvl, chgLvl, rstDone, wdExpired;

  pwr_sup_dpath #(
    .RST_CYCLES  (RST_CYCLES),
    .WD_CYCLES   (WD_CYCLES),
    .SYNC_STAGES (2)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .keyRaw    (pwrKeyIn),
    .chgRaw    (chargerIn),
    .kickRaw   (wdogKick),
    .strobe    (strobe),
    .keyLvl    (keyLvl),
    .chgLvl    (chgLvl),
    .rstDone   (rstDone),
    .wdExpired (wdExpired)
  );

  pwr_sup_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .keyLvl         (keyLvl),
    .chgLvl         (chgLvl),
    .rstDone        (rstDone),
    .wdExpired      (wdExpired),
    .battAboveStart (battAboveStart),
    .battAboveDrop  (battAboveDrop),
    .strobe         (strobe),
    .regEnable      (regEnable),
    .resetN         (resetN)
  );

endmodule

// File: rtl/pwr_sup_checker.sv
module pwr_sup_checker #(
  parameter int RST_CYCLES = 100
) (
  input logic clk,
  input logic rstN,
  input logic regEnable,
  input logic resetN,
  input logic battAboveStart,
  input logic battAboveDrop
);

  localparam int LOW_W = $clog2(RST_CYCLES + 1);
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(RST_CYCLES);

  // cycles spent with regulators up and reset asserted
  logic [LOW_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lowCnt <= '0;
    else if (regEnable && !resetN)  lowCnt <= (lowCnt == LOW_SAT) ? lowCnt : lowCnt + LOW_W'(1);
    else                            lowCnt <= '0;
  end

  // R1 / R5: reset released only with regulators up
  p_off_holds_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    !regEnable |-> !resetN);

  // R2: regulators come up into the reset state, never straight to on
  p_enter_via_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regEnable) |-> !resetN);

  // R3: reset state held for the full reset time
  p_reset_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> (lowCnt >= LOW_SAT));

  // R4: release only with battery above start threshold
  p_start_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(battAboveStart));

  // R5: on state keeps regulators enabled
  p_on_regs_r5: assert property (@(posedge clk) disable iff (!rstN)
    resetN |-> regEnable);

  // R6: dropout returns to reset with regulators kept up
  p_dropout_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resetN && !battAboveDrop) |=> (!resetN && regEnable));

endmodule

bind pwr_supervisor pwr_sup_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .regEnable      (regEnable),
  .resetN         (resetN),
  .battAboveStart (battAboveStart),
  .battAboveDrop  (battAboveDrop)
);

// File: tb/pwr_supervisor_bench.sv
module pwr_supervisor_bench;

  localparam int CLK_HZ  = 1000;
  localparam int RST_MS  = 100;
  localparam int WDOG_MS = 2000;
  localparam int N = CLK_HZ * RST_MS / 1000;
  localparam int W = CLK_HZ * WDOG_MS / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrKeyIn = 1'b0;
  logic chargerIn = 1'b0;
  logic battAboveStart = 1'b1;
  logic battAboveDrop = 1'b1;
  logic wdogKick = 1'b0;
  logic regEnable, resetN;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pwr_supervisor #(.CLK_HZ(CLK_HZ), .RST_MS(RST_MS), .WDOG_MS(WDOG_MS)) u_pwr_supervisor (
    .clk            (clk),
    .rstN           (rstN),
    .pwrKeyIn       (pwrKeyIn),
    .chargerIn      (chargerIn),
    .battAboveStart (battAboveStart),
    .battAboveDrop  (battAboveDrop),
    .wdogKick       (wdogKick),
    .regEnable      (regEnable),
    .resetN         (resetN)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic waitOn(input int limit);
    for (int i = 0; i < limit && resetN !== 1'b1; i++) tick(1);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    tick(4);
    chk("R1", "regEnable in reset", regEnable, 1'b0);
    chk("R1", "resetN in reset", resetN, 1'b0);
    rstN = 1'b1;
    tick(30);
    chk("R1", "regEnable idle", regEnable, 1'b0);
    chk("R1", "resetN idle", resetN, 1'b0);
  endtask

  task automatic t_key_power_up;
    pwrKeyIn = 1'b1;
    tick(2);
    chk("R2", "regEnable before sync latency", regEnable, 1'b0);
    tick(1);
    chk("R2", "regEnable entering reset", regEnable, 1'b1);
    chk("R2", "resetN entering reset", resetN, 1'b0);
    pwrKeyIn = 1'b0;
    tick(N - 1);
    chk("R3", "resetN at last reset cycle", resetN, 1'b0);
    tick(1);
    chk("R3", "resetN after reset time", resetN, 1'b1);
    chk("R5", "regEnable when on", regEnable, 1'b1);
    // no kicks: watchdog expires exactly W cycles after entering on
    tick(W - 1);
    chk("R7", "still on one cycle before expiry", resetN, 1'b1);
    tick(1);
    chk("R7", "regEnable after expiry", regEnable, 1'b0);
    chk("R7", "resetN after expiry", resetN, 1'b0);
    tick(20);
    chk("R1", "stays off with no cause", regEnable, 1'b0);
  endtask

  task automatic t_kick;
    pwrKeyIn = 1'b1;
    tick(4);
    pwrKeyIn = 1'b0;
    waitOn(N + 20);
    chk("R7", "on before kicking", resetN, 1'b1);
    for (int k = 0; k < 6; k++) begin
      tick(600);
      wdogKick = 1'b1;
      tick(5);
      wdogKick = 1'b0;
    end
    chk("R7", "kicked watchdog keeps on", resetN, 1'b1);
    tick(W - 200);
    chk("R7", "on shortly before timeout after last kick", resetN, 1'b1);
    tick(250);
    chk("R7", "off after timeout after last kick", regEnable, 1'b0);
  endtask

  task automatic t_kick_held;
    pwrKeyIn = 1'b1;
    tick(4);
    pwrKeyIn = 1'b0;
    waitOn(N + 20);
    wdogKick = 1'b1;
    tick(W - 1);
    chk("R9", "on before expiry with kick held", resetN, 1'b1);
    tick(1);
    chk("R9", "rising or held kick does not restart", regEnable, 1'b0);
    wdogKick = 1'b0;
    tick(10);
  endtask

  task automatic t_start_blocked;
    battAboveStart = 1'b0;
    pwrKeyIn = 1'b1;
    tick(4);
    pwrKeyIn = 1'b0;
    tick(N + 200);
    chk("R4", "regEnable while blocked", regEnable, 1'b1);
    chk("R4", "resetN held while battery low", resetN, 1'b0);
    battAboveStart = 1'b1;
    tick(1);
    chk("R4", "on at first edge with start flag", resetN, 1'b1);
  endtask

  task automatic t_dropout;
    battAboveDrop = 1'b0;
    battAboveStart = 1'b0;
    tick(1);
    chk("R6", "resetN after dropout", resetN, 1'b0);
    chk("R6", "regEnable after dropout", regEnable, 1'b1);
    battAboveDrop = 1'b1;
    battAboveStart = 1'b1;
    tick(N - 1);
    chk("R3", "reset time after dropout", resetN, 1'b0);
    tick(1);
    chk("R3", "on again after dropout reset", resetN, 1'b1);
    tick(W + 10);
    chk("R7", "off after dropout recovery", regEnable, 1'b0);
  endtask

  task automatic t_charger;
    chargerIn = 1'b1;
    tick(3);
    chk("R2", "charger enters reset", regEnable, 1'b1);
    waitOn(N + 20);
    chk("R8", "on via charger", resetN, 1'b1);
    tick(3 * W);
    chk("R8", "charger keeps on through expiries", resetN, 1'b1);
    chargerIn = 1'b0;
    tick(W + 10);
    chk("R7", "off once charger removed", regEnable, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_key_power_up();
    t_kick();
    t_kick_held();
    t_start_blocked();
    t_dropout();
    t_charger();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule